// File: doc/BRIEF.md
# Interleaved-Bank Read Current Sequencer

This block generates an endless DDR3-style command stream for measuring the supply current of a memory that is read with bank interleaving. Each clock it drives chip select, RAS, CAS, WE, ODT, CKE, the data mask level, a 3-bit bank address, a 16-bit address and an 8-bit tag that names the burst pattern the addressed memory returns for a read. The stream is paced by two spacing values, given in clock cycles. The activate-to-activate spacing (`nRRD`) sets how long each bank slot lasts. The four-activate window (`nFAW`) sets how long each group of four bank slots lasts.

A full loop has four quarters of `nFAW` cycles each. Each quarter opens four banks in turn, and each bank gets a slot of `nRRD` cycles. A slot holds an activate, then a read with auto-precharge, then deselects. The quarter is then padded with deselects until it ends. Quarters 0 and 2 use banks 0 to 3. Quarters 1 and 3 use banks 4 to 7. The second half of the loop inverts both the address nibble and the data pattern. The current sub-loop number (0 to 19) and a command-type code are brought out so that a bench can follow the stream.

A start pulse checks the two spacing values and captures them. If they are valid, the loop then runs until reset.

Top module: `bankread_seq`

## Requirements
- R1: After reset, and until a valid start, the block drives a deselect: `csN`=1, `rasN`=1, `casN`=1, `weN`=1, `cmdType`=0, `ba`=0, `addr`=0, `dataPat`=0. It also drives `subLoop`=0, `loopDone`=0 and `cfgErr`=0.
- R2: Each bank slot lasts `nRRD` cycles. Its first cycle carries an activate (`cmdType`=1), its second cycle a read with auto-precharge (`cmdType`=2), and all remaining cycles a deselect (`cmdType`=0).
- R3: The pin encodings are as follows. Activate is `csN`=0, `rasN`=0, `casN`=1, `weN`=1, with `addr[10]`=0. Read is `csN`=0, `rasN`=1, `casN`=0, `weN`=1, with `addr[10]`=1. Deselect is `csN`=1 with `rasN`, `casN` and `weN` all at 1. At most one of activate and read is issued in any cycle.
- R4: Let t be the loop cycle counted from 0, and let q = t / `nFAW`. Bank slot k (k = 0 to 3) of quarter q starts at t = q·`nFAW` + k·`nRRD`. It uses bank 4·(q mod 2) + k and reports `subLoop` = 5·q + k.
- R5: Each quarter ends with a padding sub-loop that holds only deselects. It reports `subLoop` = 5·q + 4 and holds bank 3 in quarters 0 and 2, or bank 7 in quarters 1 and 3. It lasts until the quarter's last cycle, q·`nFAW` + `nFAW` − 1. When `nFAW` = 4·`nRRD` the padding sub-loop has no cycles and does not appear.
- R6: Let h = (bank bit 0) XOR (t ≥ 2·`nFAW`). Throughout each sub-loop, `addr[6:3]` is 4'hF when h = 1 and 0 when h = 0. On the read cycle, `dataPat` is 8'h33 when h = 1 and 8'h00 when h = 0. On every other cycle `dataPat` is 0.
- R7: `odt`=0, `dm`=0 and `cke`=1 at all times. `addr[15:11]`, `addr[9:7]` and `addr[2:0]` are always 0.
- R8: A loop lasts 4·`nFAW` cycles. `loopDone` is 1 only on the last cycle of each loop, and the next cycle restarts at sub-loop 0 with an activate on bank 0.
- R9: If a start arrives while the block is idle with `nRRD` < 2 or `nFAW` < 4·`nRRD`, `cfgErr` is set and the block stays idle. If a start arrives while idle with valid values, `cfgErr` is cleared and loop cycle 0 appears in the next cycle. A start that arrives while the loop is running is ignored.
- R10: The spacing values are captured at the accepted start. Changing `nRRD` or `nFAW` while the loop is running has no effect on the stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Requests a loop start; accepted only while idle |
| nRRD | input | 8 | Activate-to-activate spacing in cycles |
| nFAW | input | 8 | Four-activate window in cycles |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| odt | output | 1 | On-die termination, held 0 |
| cke | output | 1 | Clock enable, held 1 |
| dm | output | 1 | Data mask level, held 0 |
| ba | output | 3 | Bank address |
| addr | output | 16 | Row/column address |
| dataPat | output | 8 | Burst pattern tag for the current read |
| cmdType | output | 2 | 0 deselect, 1 activate, 2 read with auto-precharge |
| subLoop | output | 5 | Current sub-loop number, 0 to 19 |
| loopDone | output | 1 | Pulses on the last cycle of each loop |
| cfgErr | output | 1 | Last start was refused for invalid spacing |

## Verification
Some properties are checked on every cycle. These are:
- an activate is always followed by a read;
- activate and read are never issued together;
- the slot counter stays below `nRRD`;
- `loopDone` is a single-cycle pulse followed by a restart at slot 0;
- an active `cfgErr` means the loop is idle.

Other behaviour can only be shown by the bench's scenarios, where a reference model recomputes the whole stream from the loop cycle number and compares it cycle by cycle. This covers:
- the absolute placement of each slot at q·`nFAW` + k·`nRRD`;
- the bank order;
- the length of the padding sub-loop, including the case where it has no cycles;
- the address and pattern inversion in the second half;
- refused and ignored starts;
- that a change to the spacing inputs during a run has no effect.

// File: rtl/bankread_pkg.sv
package bankread_pkg;
  typedef enum logic [1:0] {
    CMD_DES = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RDA = 2'd2
  } cmd_e;

  typedef struct packed {
    logic       isAct;
    logic       isRd;
    logic [2:0] bank;
    logic       inv;
  } strobe_t;
endpackage

// File: rtl/bankread_ctrl.sv
module bankread_ctrl
  import bankread_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [TW-1:0] nRRD,
  input  logic [TW-1:0] nFAW,
  output strobe_t       strb,
  output logic [4:0]    subLoop,
  output logic          loopDone,
  output logic          cfgErr
);
  localparam int CW = TW + 2;

  logic          run;
  logic [1:0]    quarter;
  logic [2:0]    slot;
  logic [TW-1:0] subCyc;
  logic [TW-1:0] qCyc;
  logic [TW-1:0] rrd;
  logic [TW-1:0] faw;

  logic badCfg;
  logic qEnd;
  logic subEnd;
  logic isPad;

  assign badCfg = (nRRD < TW'(2)) || ({2'b00, nFAW} < CW'({nRRD, 2'b00}));
  assign isPad  = slot[2];
  assign qEnd   = (qCyc == faw - 1'b1);
  assign subEnd = isPad ? qEnd : (subCyc == rrd - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      cfgErr  <= 1'b0;
      quarter <= '0;
      slot    <= '0;
      subCyc  <= '0;
      qCyc    <= '0;
      rrd     <= '0;
      faw     <= '0;
    end else if (!run) begin
      if (start) begin
        if (badCfg) begin
          cfgErr <= 1'b1;
        end else begin
          cfgErr  <= 1'b0;
          run     <= 1'b1;
          rrd     <= nRRD;
          faw     <= nFAW;
          quarter <= '0;
          slot    <= '0;
          subCyc  <= '0;
          qCyc    <= '0;
        end
      end
    end else begin
      qCyc   <= qEnd ? '0 : qCyc + 1'b1;
      subCyc <= subEnd ? '0 : subCyc + 1'b1;
      if (subEnd) begin
        if (isPad || (slot == 3'd3 && qEnd)) begin
          slot    <= '0;
          quarter <= quarter + 1'b1;
        end else begin
          slot <= slot + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.isAct = run && !isPad && (subCyc == '0);
    strb.isRd  = run && !isPad && (subCyc == TW'(1));
    strb.bank  = {quarter[0], isPad ? 2'd3 : slot[1:0]};
    strb.inv   = quarter[1];
  end

  assign subLoop  = {1'b0, quarter, 2'b00} + {3'b000, quarter} + {2'b00, slot};
  assign loopDone = run && (quarter == 2'd3) && qEnd;

  p_err_idle_r9: assert property (@(posedge clk) disable iff (rst)
    cfgErr |-> !run)
    else $error("cfgErr set while running");

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    loopDone |=> !loopDone)
    else $error("loopDone longer than one cycle");

  p_done_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    loopDone |=> (quarter == 2'd0 && slot == 3'd0 && subCyc == '0))
    else $error("loop did not restart at slot 0");

  p_slot_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (run && !isPad) |-> (subCyc < rrd))
    else $error("slot counter exceeded spacing");
endmodule

// File: rtl/bankread_dp.sv
module bankread_dp
  import bankread_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [2:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic [PAT_W-1:0]  dataPat,
  output logic [1:0]        cmdType
);
  localparam int APBIT = 10;
  localparam int NIBLO = 3;
  localparam logic [PAT_W-1:0] PAT_HI = PAT_W'(8'h33);

  logic hiNib;
  assign hiNib = strb.bank[0] ^ strb.inv;
  assign ba    = strb.bank;

  always_comb begin
    csN     = 1'b1;
    rasN    = 1'b1;
    casN    = 1'b1;
    weN     = 1'b1;
    addr    = '0;
    dataPat = '0;
    cmdType = CMD_DES;
    addr[NIBLO +: 4] = {4{hiNib}};
    if (strb.isAct) begin
      csN     = 1'b0;
      rasN    = 1'b0;
      cmdType = CMD_ACT;
    end else if (strb.isRd) begin
      csN         = 1'b0;
      casN        = 1'b0;
      addr[APBIT] = 1'b1;
      dataPat     = hiNib ? PAT_HI : '0;
      cmdType     = CMD_RDA;
    end
  end

  p_rd_follows_act_r2: assert property (@(posedge clk) disable iff (rst)
    (cmdType == CMD_ACT) |=> (cmdType == CMD_RDA))
    else $error("activate not followed by read");

  p_one_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.isAct, strb.isRd}))
    else $error("activate and read strobes together");
endmodule

// File: rtl/bankread_seq.sv
module bankread_seq
  import bankread_pkg::*;
#(
  parameter int TW     = 8,
  parameter int ADDR_W = 16,
  parameter int PAT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [TW-1:0]     nRRD,
  input  logic [TW-1:0]     nFAW,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              odt,
  output logic              cke,
  output logic              dm,
  output logic [2:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic [PAT_W-1:0]  dataPat,
  output logic [1:0]        cmdType,
  output logic [4:0]        subLoop,
  output logic              loopDone,
  output logic              cfgErr
);
  strobe_t strb;

  assign odt = 1'b0;
  assign cke = 1'b1;
  assign dm  = 1'b0;

  bankread_ctrl #(.TW(TW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .nRRD(nRRD), .nFAW(nFAW),
    .strb(strb), .subLoop(subLoop), .loopDone(loopDone), .cfgErr(cfgErr)
  );

  bankread_dp #(.ADDR_W(ADDR_W), .PAT_W(PAT_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .addr(addr), .dataPat(dataPat), .cmdType(cmdType)
  );
endmodule

// File: tb/bankread_seq_bench.sv
module bankread_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  nRRD = 8'd4;
  logic [7:0]  nFAW = 8'd20;
  logic        csN, rasN, casN, weN, odt, cke, dm, loopDone, cfgErr;
  logic [2:0]  ba;
  logic [15:0] addr;
  logic [7:0]  dataPat;
  logic [1:0]  cmdType;
  logic [4:0]  subLoop;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int doneSeen;

  always #5 clk = ~clk;

  bankread_seq u_bankread_seq (
    .clk(clk), .rst(rst), .start(start), .nRRD(nRRD), .nFAW(nFAW),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .odt(odt), .cke(cke),
    .dm(dm), .ba(ba), .addr(addr), .dataPat(dataPat), .cmdType(cmdType),
    .subLoop(subLoop), .loopDone(loopDone), .cfgErr(cfgErr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_idle(input int expErr);
    chk("R1 csN idle", csN, 1);
    chk("R1 rasN idle", rasN, 1);
    chk("R1 casN idle", casN, 1);
    chk("R1 weN idle", weN, 1);
    chk("R1 cmdType idle", cmdType, 0);
    chk("R1 ba idle", ba, 0);
    chk("R1 addr idle", addr, 0);
    chk("R1 dataPat idle", dataPat, 0);
    chk("R1 subLoop idle", subLoop, 0);
    chk("R1 loopDone idle", loopDone, 0);
    chk("R9 cfgErr", cfgErr, expErr);
  endtask

  // reference model: expected stream at loop cycle t
  task automatic check_cycle(input int t, input int rrd, input int faw);
    int q, r, p, s, cmd, bank, h, expAddr, expPat, done;
    q = t / faw;
    r = t % faw;
    if (r < 4 * rrd) begin p = r / rrd; s = r % rrd; end
    else begin p = 4; s = -1; end
    cmd  = (p < 4 && s == 0) ? 1 : (p < 4 && s == 1) ? 2 : 0;
    bank = (q % 2) * 4 + ((p < 4) ? p : 3);
    h    = (bank % 2) ^ ((t >= 2 * faw) ? 1 : 0);
    expAddr = (h ? 16'h0078 : 0) | ((cmd == 2) ? 16'h0400 : 0);
    expPat  = (cmd == 2 && h) ? 8'h33 : 0;
    done    = (t == 4 * faw - 1) ? 1 : 0;
    chk("R2 cmdType", cmdType, cmd);
    chk("R3 csN", csN, (cmd == 0) ? 1 : 0);
    chk("R3 rasN", rasN, (cmd == 1) ? 0 : 1);
    chk("R3 casN", casN, (cmd == 2) ? 0 : 1);
    chk("R3 weN", weN, 1);
    if (p < 4) begin
      chk("R4 bank", ba, bank);
      chk("R4 subLoop", subLoop, 5 * q + p);
    end else begin
      chk("R5 pad bank", ba, bank);
      chk("R5 pad subLoop", subLoop, 5 * q + 4);
    end
    chk("R6 addr", addr, expAddr);
    chk("R6 dataPat", dataPat, expPat);
    chk("R7 odt", odt, 0);
    chk("R7 dm", dm, 0);
    chk("R7 cke", cke, 1);
    chk("R8 loopDone", loopDone, done);
    chk("R9 cfgErr clear", cfgErr, 0);
    if (loopDone) doneSeen++;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_cfg(input int rrd, input int faw, input int loops, input bit retune);
    int t;
    nRRD = 8'(rrd);
    nFAW = 8'(faw);
    pulse_start();
    doneSeen = 0;
    t = 0;
    for (int n = 0; n < loops * 4 * faw; n++) begin
      check_cycle(t, rrd, faw);
      t = (t == 4 * faw - 1) ? 0 : t + 1;
      if (retune && n == 5) begin
        nRRD = 8'd2;
        nFAW = 8'd9;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    if (retune) chk("R10 loops unaffected by retune", doneSeen, loops);
    else chk("R8 loop count", doneSeen, loops);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_idle(0);

    // R9: nRRD below 2 refused
    nRRD = 8'd1; nFAW = 8'd20;
    pulse_start();
    repeat (3) begin check_idle(1); @(negedge clk); end

    // R9: nFAW below four slots refused
    nRRD = 8'd4; nFAW = 8'd15;
    pulse_start();
    check_idle(1);
    @(negedge clk);

    // padded quarters, retune and start during run (R10, R9)
    run_cfg(4, 20, 2, 1'b1);
    do_reset();
    check_idle(0);

    // no padding: nFAW equals four slots (R5)
    run_cfg(2, 8, 2, 1'b0);
    do_reset();

    // odd spacing with a short pad
    run_cfg(3, 16, 1, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule